// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor bus and the ROM and RAM of a plug-in cartridge. It turns stores into the 32 KB ROM space into writes to four small control fields: a RAM unlock, a 5-bit low ROM bank, a 2-bit upper field and a one-bit mode. From those fields and the current bus address it drives the high ROM address lines (bits 20..14), the RAM bank lines (bits 14..13) and the RAM chip select.

The lower 16 KB of ROM space always maps to bank 0. The upper 16 KB is a switchable window. A zero in the low bank field is replaced by 1, so banks 20h, 40h and 60h can never be seen through the window. In mode 0 the 2-bit field supplies ROM bank bits 6..5, which reaches up to 2 MB of ROM with a single 8 KB RAM bank. In mode 1 the same field selects one of four RAM banks (32 KB of RAM), and the upper ROM bits are held at zero (512 KB of ROM).

The register outputs change on the clock edge that takes the write. The address-driven outputs follow the bus combinationally.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the RAM is locked, the low bank field reads as 1, the upper field is 0 and mode is 0. An access to 4000h therefore gives rom_bank_o = 01h.
- R2: A write to 0000h-1FFFh unlocks RAM when wdata_i[3:0] = Ah, whatever the upper nibble holds. Any other value locks it.
- R3: A write to 2000h-3FFFh loads wdata_i[4:0] into the low bank field. A stored 0 is presented as 1.
- R4: A write to 4000h-5FFFh loads wdata_i[1:0] into the 2-bit upper field.
- R5: A write to 6000h-7FFFh loads wdata_i[0] into the mode bit.
- R6: For addresses 0000h-3FFFh, rom_bank_o is 0 in both modes.
- R7: For addresses 4000h-7FFFh, rom_bank_o is {upper, low} in mode 0 and {00b, low} in mode 1. For all other addresses it is 0.
- R8: ram_bank_o equals the upper field in mode 1 and is 0 in mode 0.
- R9: ram_cs_o is high only while rd_i or wr_i is active on A000h-BFFFh with RAM unlocked.
- R10: A read of A000h-BFFFh with RAM locked sets rdata_oe_o and drives rdata_o = FFh. Otherwise rdata_oe_o is low and rdata_o is 00h.
- R11: Writes at or above 8000h leave every control field unchanged.
- R12: Banks 20h, 40h and 60h are unreachable in mode 0: a low field of 0 with upper = n yields bank n*32+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Bus write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rom_bank_o | output | 7 | ROM address bits 20..14 |
| ram_bank_o | output | 2 | RAM address bits 14..13 |
| ram_cs_o | output | 1 | RAM chip select |
| rdata_oe_o | output | 1 | Drive the bus with rdata_o |
| rdata_o | output | 8 | Open-bus value for a locked RAM read |

## Verification
The assertions assume that rd_i and wr_i are never high in the same cycle, and that addr_i and wdata_i are held stable across the clock edge that samples a write. The stimulus changes inputs only on the falling edge and issues at most one strobe per cycle, so these assumptions hold. Each register write is followed by accesses to both ROM windows, the RAM window and unmapped space in both modes. This includes a zero low field combined with each upper value, and RAM-window writes that fall into the same address decode as the control registers' own region bits.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  parameter int unsigned LOW_W  = 5;
  parameter int unsigned HIGH_W = 2;
  parameter int unsigned BANK_W = LOW_W + HIGH_W;
  parameter logic [3:0]  UNLOCK_KEY = 4'hA;

  // field select = addr[14:13] inside the ROM space
  typedef enum logic [1:0] {
    SEL_RAM_EN = 2'd0,
    SEL_LOW    = 2'd1,
    SEL_HIGH   = 2'd2,
    SEL_MODE   = 2'd3
  } field_sel_e;

  typedef struct packed {
    logic              ram_en;
    logic [LOW_W-1:0]  low;
    logic [HIGH_W-1:0] high;
    logic              mode;
  } bank_regs_t;
endpackage

// File: rtl/cbc_reg_file.sv
module cbc_reg_file
  import cbc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  output bank_regs_t  regs_o
);
  bank_regs_t regs_q;
  logic       rom_wr;
  field_sel_e sel;

  assign rom_wr = wr_i && !addr_i[15];
  assign sel    = field_sel_e'(addr_i[14:13]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '{ram_en: 1'b0, low: '0, high: '0, mode: 1'b0};
    end else if (rom_wr) begin
      unique case (sel)
        SEL_RAM_EN: regs_q.ram_en <= (wdata_i[3:0] == UNLOCK_KEY);
        SEL_LOW:    regs_q.low    <= wdata_i[LOW_W-1:0];
        SEL_HIGH:   regs_q.high   <= wdata_i[HIGH_W-1:0];
        SEL_MODE:   regs_q.mode   <= wdata_i[0];
        default:    regs_q        <= regs_q;
      endcase
    end
  end

  assign regs_o = regs_q;

  a_r2_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b000 && wdata_i[3:0] == 4'hA) |=> regs_o.ram_en);
  a_r2_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b000 && wdata_i[3:0] != 4'hA) |=> !regs_o.ram_en);
  a_r11_high_writes_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15]) |=> $stable(regs_o));
  a_r5_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b011) |=> regs_o.mode == $past(wdata_i[0]));
endmodule

// File: rtl/cbc_addr_map.sv
module cbc_addr_map
  import cbc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  bank_regs_t        regs_i,
  output logic [BANK_W-1:0] rom_bank_o,
  output logic [HIGH_W-1:0] ram_bank_o,
  output logic              ram_cs_o,
  output logic              rdata_oe_o,
  output logic [7:0]        rdata_o
);
  logic              in_fixed, in_switch, in_ram, access;
  logic [LOW_W-1:0]  low_eff;
  logic [HIGH_W-1:0] rom_hi;

  assign in_fixed  = addr_i[15:14] == 2'b00;
  assign in_switch = addr_i[15:14] == 2'b01;
  assign in_ram    = addr_i[15:13] == 3'b101;
  assign access    = rd_i || wr_i;

  // zero in the low field never reaches the window
  assign low_eff = (regs_i.low == '0) ? LOW_W'(1) : regs_i.low;
  assign rom_hi  = regs_i.mode ? '0 : regs_i.high;

  always_comb begin
    rom_bank_o = '0;
    if (in_switch) rom_bank_o = {rom_hi, low_eff};
  end

  assign ram_bank_o = regs_i.mode ? regs_i.high : '0;
  assign ram_cs_o   = in_ram && access && regs_i.ram_en;
  assign rdata_oe_o = in_ram && rd_i && !regs_i.ram_en;
  assign rdata_o    = rdata_oe_o ? 8'hFF : 8'h00;

  a_r6_fixed_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fixed |-> rom_bank_o == '0);
  a_r3_window_nonzero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_switch |-> rom_bank_o[LOW_W-1:0] != '0);
  a_r9_cs_in_ram_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs_o |-> (addr_i[15:13] == 3'b101 && regs_i.ram_en));
  a_r10_cs_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_cs_o && rdata_oe_o));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [6:0]  rom_bank_o,
  output logic [1:0]  ram_bank_o,
  output logic        ram_cs_o,
  output logic        rdata_oe_o,
  output logic [7:0]  rdata_o
);
  bank_regs_t regs;

  cbc_reg_file u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_i    (wr_i),
    .regs_o  (regs)
  );

  cbc_addr_map u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .regs_i     (regs),
    .rom_bank_o (rom_bank_o),
    .ram_bank_o (ram_bank_o),
    .ram_cs_o   (ram_cs_o),
    .rdata_oe_o (rdata_oe_o),
    .rdata_o    (rdata_o)
  );

  a_r8_ram_bank_mode0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs.mode |-> ram_bank_o == 2'b00);
  a_r7_mode1_rom_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs.mode |-> rom_bank_o[6:5] == 2'b00);
endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_cs, rdata_oe;
  logic [7:0]  rdata;

  int n_cmp = 0, n_bad = 0;
  int m_en = 0, m_low = 0, m_high = 0, m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rom_bank_o(rom_bank), .ram_bank_o(ram_bank),
    .ram_cs_o(ram_cs), .rdata_oe_o(rdata_oe), .rdata_o(rdata)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s addr=%h actual=%0h expected=%0h", req, what, addr, act, exp);
    end
  endtask

  task automatic compare(string req);
    int a, lo, exp_rom, exp_ram, exp_cs, exp_oe;
    a = int'(addr);
    lo = (m_low == 0) ? 1 : m_low;
    exp_rom = 0;
    if (a >= 'h4000 && a < 'h8000) exp_rom = m_mode ? lo : m_high * 32 + lo;
    exp_ram = m_mode ? m_high : 0;
    exp_cs  = (a >= 'hA000 && a < 'hC000 && m_en != 0 && (rd || wr)) ? 1 : 0;
    exp_oe  = (a >= 'hA000 && a < 'hC000 && m_en == 0 && rd) ? 1 : 0;
    chk(req, "rom_bank", int'(rom_bank), exp_rom);
    chk(req, "ram_bank", int'(ram_bank), exp_ram);
    chk(req, "ram_cs", int'(ram_cs), exp_cs);
    chk(req, "rdata_oe", int'(rdata_oe), exp_oe);
    chk(req, "rdata", int'(rdata), exp_oe ? 'hFF : 0);
  endtask

  task automatic model_write(int a, int d);
    if (a < 'h2000) m_en = ((d % 16) == 'hA) ? 1 : 0;
    else if (a < 'h4000) m_low = d % 32;
    else if (a < 'h6000) m_high = d % 4;
    else if (a < 'h8000) m_mode = d % 2;
  endtask

  // one bus cycle: drive on falling edge, compare, model follows rising edge
  task automatic cyc(string req, int a, int d, bit w, bit r);
    @(negedge clk);
    addr = 16'(a); wdata = 8'(d); wr = w; rd = r;
    #1 compare(req);
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic probe(string req);
    cyc(req, 'h0123, 0, 0, 1);
    cyc(req, 'h3FFF, 0, 0, 1);
    cyc(req, 'h4000, 0, 0, 1);
    cyc(req, 'h7ABC, 0, 0, 1);
    cyc(req, 'hA010, 0, 0, 1);
    cyc(req, 'hBFFF, 0, 1, 0);
    cyc(req, 'hC000, 0, 0, 1);
    cyc(req, 'h8000, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    probe("R1");
    cyc("R2", 'h0000, 'h0A, 1, 0);  probe("R2");
    cyc("R2", 'h1FFF, 'h0B, 1, 0);  probe("R2");
    cyc("R2", 'h1000, 'hFA, 1, 0);  probe("R9");
    cyc("R10", 'h0000, 'h00, 1, 0); probe("R10");
    cyc("R2", 'h0001, 'h3A, 1, 0);
    for (int v = 0; v < 40; v += 7) begin
      cyc("R3", 'h2000 + v * 97, v, 1, 0);
      probe("R3");
    end
    cyc("R3", 'h3000, 'hE0, 1, 0); probe("R3");
    for (int u = 0; u < 4; u++) begin
      cyc("R4", 'h4000 + u, u, 1, 0);
      cyc("R12", 'h2000, 'h00, 1, 0);
      probe("R12");
      cyc("R12", 'h2100, 'h20, 1, 0);
      probe("R12");
      cyc("R7", 'h2000, 'h13, 1, 0);
      probe("R7");
    end
    cyc("R4", 'h5FFF, 'hFE, 1, 0);
    cyc("R5", 'h6000, 'h01, 1, 0);  probe("R8");
    cyc("R5", 'h7FFF, 'hFF, 1, 0);  probe("R7");
    cyc("R4", 'h4321, 'h01, 1, 0);  probe("R8");
    for (int a = 'h8000; a < 'h10000; a += 'h1F00) begin
      cyc("R11", a, 'h00, 1, 0);
      probe("R11");
    end
    cyc("R5", 'h6000, 'h02, 1, 0);  probe("R6");
    cyc("R2", 'h0000, 'h05, 1, 0);  probe("R10");
    rst_ni = 1'b0;
    m_en = 0; m_low = 0; m_high = 0; m_mode = 0;
    #1 rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    probe("R1");
    summary();
  end
endmodule